// File: doc/BRIEF.md
# Next-Block Prefetch Trigger Controller

This block sits beside a fully associative buffer of large cache blocks and decides when the block that follows a just-hit block should be brought in ahead of demand. Every buffer hit is reported with the entry's tag, its "already prefetched" flag, and its vector of per-sub-block reference flags. When the flag is clear and enough sub-blocks of the hit block have been referenced, the block spends one extra cycle asking the buffer whether the successor tag (tag + 1) is already resident. If it is, or if the one-entry prefetch holding register already has it, no memory traffic is made. Otherwise one fetch request goes to memory, and the returned line lands in the holding register, where the miss handler can later pick it up.

In both outcomes the hit entry's "already prefetched" flag is set during the search cycle, so the same block never starts a second prefetch. The referenced-count threshold can be selected as two or four. A busy output tells the miss handler that a search or fetch is in progress. Three event counters count triggers, issued fetches and suppressed fetches.

The controller is a three-state machine:
- `ST_IDLE`: waits for a qualifying hit.
- `ST_SEARCH`: one cycle; the tag probe is driven and the flag is set.
- `ST_FETCH`: the request is held until memory acknowledges.

There are five transitions:
- IDLE→SEARCH on a trigger.
- SEARCH→IDLE when the successor is found.
- SEARCH→FETCH when the successor is absent.
- FETCH→FETCH while no acknowledge arrives.
- FETCH→IDLE on acknowledge.

Top module: `nbp_ctrl`

## Requirements
- R1: A trigger occurs only when all of these hold in the same cycle: `hit_vld` is 1, `hit_pbit` is 0, the controller is idle, and the number of ones in `hit_bits` is at least the threshold. The threshold is 2 when `cfg_thr_four` is 0 and 4 when it is 1. Any other hit causes no search, no flag write and no count change.
- R2: The cycle after a trigger is the search cycle, and it lasts exactly one cycle. In it, `srch_vld` is 1 and `srch_tag` equals the hit tag plus one modulo 2^TAG_W, so an all-ones tag wraps to zero.
- R3: In the search cycle of every trigger, whatever the search outcome, `set_p_vld` is 1 and `set_p_entry` equals the `hit_entry` of the trigger.
- R4: The successor counts as found when, in the search cycle, `srch_hit` is 1 or the holding register is valid with a tag equal to the successor tag. When it is found, no request is raised, the controller is idle in the next cycle, and `cnt_supp` increments by one.
- R5: When the successor is not found, `pf_req` rises in the next cycle with `pf_tag` equal to the successor tag. Both are held stable until `pf_ack`, and `cnt_fetch` increments by one.
- R6: In the cycle after `pf_req` and `pf_ack` are both high, `pbuf_vld` is 1, `pbuf_tag` is the fetched tag, `pbuf_data` is the `pf_data` sampled with the acknowledge, and the controller is idle.
- R7: `busy` is 1 from the search cycle through the acknowledge cycle. Hits arriving while busy are ignored: they set no flag, start no search and do not change `cnt_trig`.
- R8: A `pbuf_take` pulse with no load in the same cycle leaves `pbuf_vld` at 0 in the next cycle.
- R9: After reset the controller is idle: `busy`, `srch_vld`, `set_p_vld`, `pf_req` and `pbuf_vld` are 0, and all three counters are 0.
- R10: `cnt_trig` increments by exactly one for each trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_thr_four | input | 1 | Threshold select: 0 means two referenced sub-blocks, 1 means four |
| hit_vld | input | 1 | Spatial buffer hit this cycle |
| hit_tag | input | TAG_W | Tag of the hit large block |
| hit_pbit | input | 1 | Hit entry already prefetched |
| hit_bits | input | SUB_N | Per-sub-block referenced flags of the hit entry |
| hit_entry | input | ENT_W | Index of the hit entry |
| srch_vld | output | 1 | Tag probe of the buffer in this cycle |
| srch_tag | output | TAG_W | Successor tag being probed |
| srch_hit | input | 1 | Probe result, valid in the same cycle |
| set_p_vld | output | 1 | Set the prefetched flag of an entry |
| set_p_entry | output | ENT_W | Entry whose flag is set |
| pf_req | output | 1 | Memory fetch request |
| pf_tag | output | TAG_W | Tag to fetch |
| pf_ack | input | 1 | Memory returns the line |
| pf_data | input | LINE_W | Returned line |
| pbuf_take | input | 1 | Miss handler consumes the holding register |
| pbuf_vld | output | 1 | Holding register full |
| pbuf_tag | output | TAG_W | Tag in holding register |
| pbuf_data | output | LINE_W | Line in holding register |
| busy | output | 1 | Search or fetch in progress |
| cnt_trig | output | CNT_W | Triggers generated |
| cnt_fetch | output | CNT_W | Fetches issued |
| cnt_supp | output | CNT_W | Fetches suppressed |

## Verification
Random hits mix the prefetched flag, every reference-count value and both threshold settings. This separates an off-by-one threshold and a swapped threshold select from a correct one. The probe result is random, and the holding register's content is sometimes the very successor, so suppression from each of its two sources is told apart from a real fetch. Memory latency varies from zero to several cycles, with qualifying hits injected while the fetch waits; this shows whether busy-time hits leak into flag writes or counts. Directed cases cover the all-ones tag wrap and draining of the holding register.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_FETCH  = 2'd2
    } nbp_state_e;
endpackage

// File: rtl/nbp_qualify.sv
module nbp_qualify #(
    parameter int TAG_W  = 27,
    parameter int SUB_N  = 4,
    parameter int THR_LO = 2,
    parameter int THR_HI = 4
) (
    input  logic             hit_vld,
    input  logic             hit_pbit,
    input  logic [SUB_N-1:0] hit_bits,
    input  logic [TAG_W-1:0] hit_tag,
    input  logic             cfg_thr_four,
    input  logic             idle,
    output logic             trig,
    output logic [TAG_W-1:0] next_tag
);
    localparam int CW = $clog2(SUB_N + 1);

    logic [CW-1:0] ones;
    int            thr_sel;
    logic          met;

    // population count of referenced sub-blocks
    always_comb begin
        ones = '0;
        for (int k = 0; k < SUB_N; k++) begin
            ones = ones + CW'(hit_bits[k]);
        end
    end

    always_comb begin
        thr_sel = cfg_thr_four ? THR_HI : THR_LO;
        met     = (int'(ones) >= thr_sel);
        trig    = hit_vld & idle & ~hit_pbit & met;
    end

    // successor tag, carry out of the top bit dropped
    assign next_tag = hit_tag + TAG_W'(1);
endmodule

// File: rtl/nbp_fsm.sv
module nbp_fsm
    import nbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic found,
    input  logic pf_ack,
    output logic idle,
    output logic in_search,
    output logic in_fetch,
    output logic ev_fetch,
    output logic ev_supp
);
    nbp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (trig) state_d = ST_SEARCH;
            ST_SEARCH: state_d = found ? ST_IDLE : ST_FETCH;
            ST_FETCH:  if (pf_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle      = (state_q == ST_IDLE);
        in_search = (state_q == ST_SEARCH);
        in_fetch  = (state_q == ST_FETCH);
        ev_fetch  = in_search & ~found;
        ev_supp   = in_search & found;
    end

    assert_trig_to_search_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> in_search);
    assert_search_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_search |=> !in_search);
    assert_found_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_search && found) |=> idle);
    assert_absent_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_search && !found) |=> in_fetch);
    assert_fetch_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fetch && !pf_ack) |=> in_fetch);
    assert_ack_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fetch && pf_ack) |=> idle);
endmodule

// File: rtl/nbp_pbuf.sv
module nbp_pbuf #(
    parameter int TAG_W  = 27,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              take,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic [LINE_W-1:0] data_in,
    output logic              vld,
    output logic [TAG_W-1:0]  tag,
    output logic [LINE_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            tag  <= '0;
            data <= '0;
        end else if (load) begin
            vld  <= 1'b1;
            tag  <= tag_in;
            data <= data_in;
        end else if (take) begin
            vld  <= 1'b0;
        end
    end

    assert_load_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (vld && tag == $past(tag_in) && data == $past(data_in)));
    assert_take_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !load) |=> !vld);
endmodule

// File: rtl/nbp_counters.sv
module nbp_counters #(
    parameter int NUM   = 3,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] cnt
);
    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt[g] <= '0;
            else if (inc[g]) cnt[g] <= cnt[g] + CNT_W'(1);
        end

        assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
            inc[g] |=> (cnt[g] == $past(cnt[g]) + CNT_W'(1)));
        assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !inc[g] |=> $stable(cnt[g]));
    end
endmodule

// File: rtl/nbp_ctrl.sv
module nbp_ctrl #(
    parameter int TAG_W   = 27,
    parameter int SUB_N   = 4,
    parameter int ENTRIES = 8,
    parameter int LINE_W  = 64,
    parameter int CNT_W   = 16,
    parameter int THR_LO  = 2,
    parameter int THR_HI  = 4,
    localparam int ENT_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_thr_four,
    input  logic              hit_vld,
    input  logic [TAG_W-1:0]  hit_tag,
    input  logic              hit_pbit,
    input  logic [SUB_N-1:0]  hit_bits,
    input  logic [ENT_W-1:0]  hit_entry,
    output logic              srch_vld,
    output logic [TAG_W-1:0]  srch_tag,
    input  logic              srch_hit,
    output logic              set_p_vld,
    output logic [ENT_W-1:0]  set_p_entry,
    output logic              pf_req,
    output logic [TAG_W-1:0]  pf_tag,
    input  logic              pf_ack,
    input  logic [LINE_W-1:0] pf_data,
    input  logic              pbuf_take,
    output logic              pbuf_vld,
    output logic [TAG_W-1:0]  pbuf_tag,
    output logic [LINE_W-1:0] pbuf_data,
    output logic              busy,
    output logic [CNT_W-1:0]  cnt_trig,
    output logic [CNT_W-1:0]  cnt_fetch,
    output logic [CNT_W-1:0]  cnt_supp
);
    localparam int NCNT = 3;

    logic             trig, idle, in_search, in_fetch, ev_fetch, ev_supp, found;
    logic [TAG_W-1:0] next_tag, succ_q;
    logic [ENT_W-1:0] ent_q;
    logic [NCNT-1:0][CNT_W-1:0] cnts;

    nbp_qualify #(.TAG_W(TAG_W), .SUB_N(SUB_N), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_qual (
        .hit_vld(hit_vld), .hit_pbit(hit_pbit), .hit_bits(hit_bits), .hit_tag(hit_tag),
        .cfg_thr_four(cfg_thr_four), .idle(idle), .trig(trig), .next_tag(next_tag)
    );

    // capture the successor tag and the hit entry when a trigger is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            succ_q <= '0;
            ent_q  <= '0;
        end else if (trig) begin
            succ_q <= next_tag;
            ent_q  <= hit_entry;
        end
    end

    assign found = srch_hit | (pbuf_vld & (pbuf_tag == succ_q));

    nbp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .trig(trig), .found(found), .pf_ack(pf_ack),
        .idle(idle), .in_search(in_search), .in_fetch(in_fetch),
        .ev_fetch(ev_fetch), .ev_supp(ev_supp)
    );

    nbp_pbuf #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .load(in_fetch & pf_ack), .take(pbuf_take),
        .tag_in(succ_q), .data_in(pf_data),
        .vld(pbuf_vld), .tag(pbuf_tag), .data(pbuf_data)
    );

    nbp_counters #(.NUM(NCNT), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc({ev_supp, ev_fetch, trig}), .cnt(cnts)
    );

    always_comb begin
        srch_vld    = in_search;
        srch_tag    = succ_q;
        set_p_vld   = in_search;
        set_p_entry = ent_q;
        pf_req      = in_fetch;
        pf_tag      = succ_q;
        busy        = ~idle;
        cnt_trig    = cnts[0];
        cnt_fetch   = cnts[1];
        cnt_supp    = cnts[2];
    end

    assert_req_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_req && !pf_ack) |=> (pf_req && $stable(pf_tag)));
    assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !srch_vld && !pf_req) |-> 1'b0);
    assert_setp_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_p_vld |=> !set_p_vld);
    assert_no_probe_in_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req |-> !srch_vld);
endmodule

// File: tb/nbp_ctrl_tb.sv
module nbp_ctrl_tb_top;
    localparam int TAG_W  = 27;
    localparam int SUB_N  = 4;
    localparam int ENT_W  = 3;
    localparam int LINE_W = 64;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_thr_four = 1'b0;
    logic hit_vld = 1'b0, hit_pbit = 1'b0;
    logic [TAG_W-1:0] hit_tag = '0;
    logic [SUB_N-1:0] hit_bits = '0;
    logic [ENT_W-1:0] hit_entry = '0;
    logic srch_vld, srch_hit, set_p_vld, pf_req, pbuf_vld, busy;
    logic [TAG_W-1:0] srch_tag, pf_tag, pbuf_tag;
    logic [ENT_W-1:0] set_p_entry;
    logic pf_ack = 1'b0, pbuf_take = 1'b0;
    logic [LINE_W-1:0] pf_data = '0, pbuf_data;
    logic [CNT_W-1:0] cnt_trig, cnt_fetch, cnt_supp;

    logic resp_present = 1'b0;
    logic [TAG_W-1:0] resp_tag = '0;
    assign srch_hit = resp_present && srch_vld && (srch_tag == resp_tag);

    int checks = 0, failures = 0;
    int n_trig = 0, n_fetch = 0, n_supp = 0;
    bit exp_pb_vld = 0;
    logic [TAG_W-1:0] exp_pb_tag = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nbp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_thr_four(cfg_thr_four),
        .hit_vld(hit_vld), .hit_tag(hit_tag), .hit_pbit(hit_pbit), .hit_bits(hit_bits),
        .hit_entry(hit_entry), .srch_vld(srch_vld), .srch_tag(srch_tag), .srch_hit(srch_hit),
        .set_p_vld(set_p_vld), .set_p_entry(set_p_entry), .pf_req(pf_req), .pf_tag(pf_tag),
        .pf_ack(pf_ack), .pf_data(pf_data), .pbuf_take(pbuf_take), .pbuf_vld(pbuf_vld),
        .pbuf_tag(pbuf_tag), .pbuf_data(pbuf_data), .busy(busy),
        .cnt_trig(cnt_trig), .cnt_fetch(cnt_fetch), .cnt_supp(cnt_supp)
    );

    function automatic logic [LINE_W-1:0] line_of(input logic [TAG_W-1:0] t);
        return {t, ~t, 10'h2A5};
    endfunction

    function automatic bit qualifies(input bit pb, input logic [SUB_N-1:0] hb, input bit four);
        return !pb && ($countones(hb) >= (four ? 4 : 2));
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic run_event(input logic [TAG_W-1:0] t, input bit pb, input logic [SUB_N-1:0] hb,
                             input logic [ENT_W-1:0] e, input bit pres, input int lat, input bit stray);
        logic [TAG_W-1:0] nt;
        bit trg, fnd;
        nt  = t + TAG_W'(1);
        trg = qualifies(pb, hb, cfg_thr_four);
        fnd = pres || (exp_pb_vld && exp_pb_tag == nt);
        @(negedge clk);
        resp_present = pres; resp_tag = nt;
        hit_tag = t; hit_pbit = pb; hit_bits = hb; hit_entry = e; hit_vld = 1'b1;
        @(negedge clk);
        hit_vld = 1'b0;
        if (!trg) begin
            chk("R1 no search", srch_vld, 0);
            chk("R1 no flag", set_p_vld, 0);
            chk("R1 trig count", cnt_trig, n_trig);
            return;
        end
        n_trig++;
        chk("R2 probe", srch_vld, 1);
        chk("R2 successor tag", srch_tag, nt);
        chk("R3 flag", set_p_vld, 1);
        chk("R3 entry", set_p_entry, e);
        chk("R7 busy search", busy, 1);
        chk("R10 trig count", cnt_trig, n_trig);
        @(negedge clk);
        chk("R2 probe one cycle", srch_vld, 0);
        if (fnd) begin
            n_supp++;
            chk("R4 no req", pf_req, 0);
            chk("R4 idle", busy, 0);
            chk("R4 supp count", cnt_supp, n_supp);
            chk("R4 fetch count", cnt_fetch, n_fetch);
            return;
        end
        n_fetch++;
        chk("R5 req", pf_req, 1);
        chk("R5 tag", pf_tag, nt);
        chk("R5 fetch count", cnt_fetch, n_fetch);
        for (int i = 0; i < lat; i++) begin
            if (i == 0 && stray) begin
                hit_tag = t + TAG_W'(7); hit_pbit = 1'b0; hit_bits = '1; hit_vld = 1'b1;
            end
            @(negedge clk);
            hit_vld = 1'b0;
            chk("R7 no flag while busy", set_p_vld, 0);
            chk("R7 trig count while busy", cnt_trig, n_trig);
            chk("R7 busy fetch", busy, 1);
            chk("R5 req held", pf_req, 1);
            chk("R5 tag held", pf_tag, nt);
        end
        pf_ack = 1'b1; pf_data = line_of(nt);
        @(negedge clk);
        pf_ack = 1'b0;
        exp_pb_vld = 1; exp_pb_tag = nt;
        chk("R6 pbuf vld", pbuf_vld, 1);
        chk("R6 pbuf tag", pbuf_tag, nt);
        chk("R6 pbuf data", pbuf_data, line_of(nt));
        chk("R6 idle", busy, 0);
        chk("R6 req dropped", pf_req, 0);
    endtask

    task automatic take_pbuf();
        @(negedge clk);
        pbuf_take = 1'b1;
        @(negedge clk);
        pbuf_take = 1'b0;
        exp_pb_vld = 0;
        chk("R8 pbuf cleared", pbuf_vld, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 busy", busy, 0);
        chk("R9 probe", srch_vld, 0);
        chk("R9 flag", set_p_vld, 0);
        chk("R9 req", pf_req, 0);
        chk("R9 pbuf", pbuf_vld, 0);
        chk("R9 counters", {cnt_trig, cnt_fetch, cnt_supp}, 0);

        // directed corners
        cfg_thr_four = 1'b0;
        run_event(27'h0000100, 0, 4'b0001, 3'd1, 0, 0, 0);   // R1 one ref below two
        run_event(27'h0000100, 0, 4'b0101, 3'd2, 0, 2, 1);   // R1 exactly two, fetch, stray R7
        run_event(27'h0000100, 0, 4'b1111, 3'd3, 0, 0, 0);   // R4 successor already in pbuf
        run_event(27'h0000100, 1, 4'b1111, 3'd3, 0, 0, 0);   // R1 flag already set
        cfg_thr_four = 1'b1;
        run_event(27'h0000200, 0, 4'b0111, 3'd4, 0, 0, 0);   // R1 three below four
        run_event(27'h0000200, 0, 4'b1111, 3'd4, 1, 0, 0);   // R4 found by probe
        run_event(27'h7FFFFFF, 0, 4'b1111, 3'd7, 0, 1, 0);   // R2 wrap to zero
        take_pbuf();                                         // R8

        for (int n = 0; n < 400; n++) begin
            cfg_thr_four = ($urandom % 2) == 1;
            run_event(TAG_W'($urandom % 64), ($urandom % 4) == 0, SUB_N'($urandom),
                      ENT_W'($urandom), ($urandom % 3) == 0, int'($urandom % 4), ($urandom % 2) == 1);
            if ($urandom % 4 == 0) take_pbuf();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule